// File: doc/BRIEF.md
# Single-Channel Timer Compare Unit

This block is one timer counter with one compare channel. The counter runs either edge-aligned (counting up from 0 to the reload value, then wrapping to 0) or center-aligned (counting up to the reload value, then back down to 0, turning at each end). In every cycle where the counter is running and equals the active compare value, the block raises a compare event. Each event sets a sticky compare flag and, in toggle mode, inverts the output reference. Two matches on back-to-back cycles, caused by a compare value that changes between them, produce two events. This holds at the edge-aligned wrap, at the center-aligned crest and at the center-aligned valley, so a toggling output can show a pulse one clock wide.

Software writes the compare and reload values through a small write port. With preload off, a written value takes effect on the next cycle. With preload on, the value waits in a shadow register and is copied into the active register at an update event. Update opportunities are the wrap point in edge-aligned mode, and the crest and the valley in center-aligned mode. A repetition down-counter lets only every (N+1)-th opportunity become an update event.

The direction control is a two-state machine. State UP counts up. At the top it either wraps to 0 (edge-aligned; the transition UP→UP is the wrap) or moves to DOWN (center-aligned; the transition UP→DOWN is the crest). State DOWN counts down. At 0 it moves back to UP (the transition DOWN→UP is the valley). If edge-aligned mode is selected while in DOWN, the machine returns to UP at once and counts up.

Top module: `tmr_oc_unit`

## Requirements
- R1: After reset the counter is 0 and counts up, the output reference and the compare flag are 0, the active compare value is 0 and the active reload value is the ARR_RST parameter (10 by default).
- R2: In edge-aligned mode (`center`=0), a running counter increments each cycle. In a cycle where it is at or above the active reload value, it wraps to 0 on the next cycle instead, and that cycle is an update opportunity.
- R3: In center-aligned mode (`center`=1), the counter counts up to the reload value and then down to 0, with `count_down`=1 while it is descending. The crest cycle (counter at or above reload while ascending) is followed by reload−1. The valley cycle (counter 0 while descending) is followed by 1. Both are update opportunities.
- R4: `cmp_evt` is 1 in exactly those cycles where `en`=1 and the counter equals the active compare value. While `en`=0 the counter, the direction, the repetition count and the update logic are frozen.
- R5: In edge-aligned mode, a compare value preloaded from ARR to 0 gives events both at counter=ARR and at counter=0 on the next cycle.
- R6: In center-aligned ascent, a compare value changed from ARR−1 to ARR gives events both at ARR−1 and at ARR on the next cycle.
- R7: In center-aligned descent, a compare value changed from 1 to 0 gives events both at 1 and at 0 on the next cycle.
- R8: With `tog_en`=1, `oc_ref` inverts on the clock edge that ends each event cycle, so two consecutive events give a one-cycle pulse. With `tog_en`=0, or when there is no event, `oc_ref` holds.
- R9: `cmp_flag` is set by each event and stays set until a cycle with `flag_clr`=1 and no event. A set in the same cycle as a clear wins.
- R10: A write (`wr_en`=1; `wr_sel`=0 selects compare, 1 selects reload) always loads the shadow value. With `preload`=0 it also loads the active value, which takes effect on the next cycle.
- R11: With `preload`=1, an update event (`upd_evt`) copies both shadow values into the active values, effective from the next cycle. Writes in that mode leave the active values unchanged.
- R12: An update opportunity becomes an update event only when the repetition count is 0. At that opportunity the count reloads from `rep_val`; at every other opportunity it decrements. The count is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter run enable |
| center | input | 1 | 0 edge-aligned, 1 center-aligned |
| preload | input | 1 | 1 buffers writes until the update event |
| tog_en | input | 1 | 1 makes each event invert the output reference |
| flag_clr | input | 1 | Clears the compare flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 compare value, 1 reload value |
| wr_data | input | CW | Write data |
| rep_val | input | RW | Repetition reload value |
| cnt | output | CW | Counter value |
| count_down | output | 1 | 1 while the counter descends |
| cmp_evt | output | 1 | Compare event in this cycle |
| upd_evt | output | 1 | Update event in this cycle |
| oc_ref | output | 1 | Output reference |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The checker assumes that the reload value is at least 1 whenever center-aligned mode runs, because a zero reload has no defined crest. The stimulus never writes a reload value below 1. It also assumes `en` is a plain level held across a full cycle, which the bench guarantees by driving every input at the falling edge. The random stimulus keeps reload values small (1 to 10) and compare values from 0 to one above the reload value, so that matches, wraps, crests and valleys occur often. Directed sequences then set up the back-to-back matches at the wrap, the crest and the valley.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
    typedef enum logic {
        S_UP   = 1'b0,
        S_DOWN = 1'b1
    } dir_state_t;

    localparam logic SEL_CMP = 1'b0;
    localparam logic SEL_ARR = 1'b1;
endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          center,
    input  logic [CW-1:0] arr_act,
    input  logic [RW-1:0] rep_val,
    output logic [CW-1:0] cnt,
    output logic          count_down,
    output logic          upd
);
    localparam logic [CW-1:0] ONE = CW'(1);

    dir_state_t    st, st_nxt;
    logic [CW-1:0] cnt_nxt;
    logic [RW-1:0] rep;
    logic          opp;

    // next-state and counter step
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        opp     = 1'b0;
        if (en) begin
            unique case (st)
                S_UP: begin
                    if (cnt >= arr_act) begin
                        opp = 1'b1;
                        if (center) begin
                            st_nxt  = S_DOWN;
                            cnt_nxt = arr_act - ONE;
                        end else begin
                            cnt_nxt = '0;
                        end
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
                S_DOWN: begin
                    if (!center) begin
                        st_nxt  = S_UP;
                        cnt_nxt = cnt + ONE;
                    end else if (cnt == '0) begin
                        opp     = 1'b1;
                        st_nxt  = S_UP;
                        cnt_nxt = ONE;
                    end else begin
                        cnt_nxt = cnt - ONE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_UP;
            cnt <= '0;
            rep <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (opp) begin
                rep <= (rep == '0) ? rep_val : rep - RW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        count_down = (st == S_DOWN);
        upd        = opp && (rep == '0);
    end
endmodule

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16,
    parameter logic [CW-1:0] ARR_RST = CW'(10)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preload,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          upd,
    output logic [CW-1:0] cmp_act,
    output logic [CW-1:0] arr_act
);
    logic [CW-1:0] cmp_sh, arr_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_sh  <= '0;
            cmp_act <= '0;
            arr_sh  <= ARR_RST;
            arr_act <= ARR_RST;
        end else begin
            if (upd && preload) begin
                cmp_act <= cmp_sh;
                arr_act <= arr_sh;
            end
            if (wr_en) begin
                if (wr_sel == SEL_CMP) begin
                    cmp_sh <= wr_data;
                    if (!preload) cmp_act <= wr_data;
                end else begin
                    arr_sh <= wr_data;
                    if (!preload) arr_act <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tog_en,
    input  logic          flag_clr,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_act,
    output logic          evt,
    output logic          oc_ref,
    output logic          cmp_flag
);
    // level compare: every matching cycle is an event, even back to back
    assign evt = en && (cnt == cmp_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_ref   <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (evt && tog_en) oc_ref <= ~oc_ref;
            if (evt)           cmp_flag <= 1'b1;
            else if (flag_clr) cmp_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_oc_unit.sv
module tmr_oc_unit #(
    parameter int CW = 16,
    parameter int RW = 4,
    parameter logic [CW-1:0] ARR_RST = CW'(10)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          center,
    input  logic          preload,
    input  logic          tog_en,
    input  logic          flag_clr,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic [RW-1:0] rep_val,
    output logic [CW-1:0] cnt,
    output logic          count_down,
    output logic          cmp_evt,
    output logic          upd_evt,
    output logic          oc_ref,
    output logic          cmp_flag
);
    logic [CW-1:0] cmp_act;
    logic [CW-1:0] arr_act;

    tmr_oc_counter #(.CW(CW), .RW(RW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .center(center),
        .arr_act(arr_act), .rep_val(rep_val),
        .cnt(cnt), .count_down(count_down), .upd(upd_evt)
    );

    tmr_oc_regs #(.CW(CW), .ARR_RST(ARR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .preload(preload),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd(upd_evt), .cmp_act(cmp_act), .arr_act(arr_act)
    );

    tmr_oc_compare #(.CW(CW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .tog_en(tog_en),
        .flag_clr(flag_clr), .cnt(cnt), .cmp_act(cmp_act),
        .evt(cmp_evt), .oc_ref(oc_ref), .cmp_flag(cmp_flag)
    );
endmodule

// File: rtl/tmr_oc_chk.sv
module tmr_oc_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          center,
    input logic          tog_en,
    input logic          flag_clr,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] arr_act,
    input logic          count_down,
    input logic          cmp_evt,
    input logic          upd_evt,
    input logic          oc_ref,
    input logic          cmp_flag
);
    // R8
    ref_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && tog_en) |=> (oc_ref != $past(oc_ref)));
    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_evt && tog_en) |=> $stable(oc_ref));
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> cmp_flag);
    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);
    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt) && $stable(count_down)));
    // R4
    idle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(cmp_evt || upd_evt));
    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !center && !count_down && cnt >= arr_act) |=> (cnt == '0));
    // R3
    valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && center && count_down && cnt == '0) |=> (cnt == CW'(1) && !count_down));
    // R12
    upd_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> ((!count_down && cnt >= arr_act) || (count_down && center && cnt == '0)));
endmodule

bind tmr_oc_unit tmr_oc_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .center(center), .tog_en(tog_en),
    .flag_clr(flag_clr), .cnt(cnt), .arr_act(arr_act),
    .count_down(count_down), .cmp_evt(cmp_evt), .upd_evt(upd_evt),
    .oc_ref(oc_ref), .cmp_flag(cmp_flag)
);

// File: tb/sim_tmr_oc_unit.sv
`timescale 1ns/1ps
module sim_tmr_oc_unit;
    localparam int CW = 16;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, center = 0, preload = 0, tog_en = 0, flag_clr = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [CW-1:0] wr_data = '0;
    logic [RW-1:0] rep_val = '0;
    logic [CW-1:0] cnt;
    logic count_down, cmp_evt, upd_evt, oc_ref, cmp_flag;

    always #4 clk = ~clk;   // 125 MHz

    tmr_oc_unit u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .center(center), .preload(preload),
        .tog_en(tog_en), .flag_clr(flag_clr), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rep_val(rep_val), .cnt(cnt), .count_down(count_down),
        .cmp_evt(cmp_evt), .upd_evt(upd_evt), .oc_ref(oc_ref), .cmp_flag(cmp_flag)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // bench reference state
    logic [CW-1:0] m_cnt = '0, m_cmp = '0, m_csh = '0, m_arr = CW'(10), m_ash = CW'(10);
    logic [RW-1:0] m_rep = '0;
    logic m_down = 0, m_ref = 0, m_flag = 0, m_evt = 0, m_upd = 0;
    logic seen_evt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic f_opp(input logic [CW-1:0] c, input logic d,
                                   input logic cen, input logic [CW-1:0] a);
        if (!d) return c >= a;
        return cen && (c == '0);
    endfunction

    task automatic model_step();
        logic [CW-1:0] n_cnt;
        logic n_down, opp;
        opp = en && f_opp(m_cnt, m_down, center, m_arr);
        n_cnt = m_cnt; n_down = m_down;
        if (en) begin
            if (!m_down) begin
                if (m_cnt >= m_arr) begin
                    if (center) begin n_down = 1; n_cnt = m_arr - 1; end
                    else n_cnt = '0;
                end else n_cnt = m_cnt + 1;
            end else if (!center) begin
                n_down = 0; n_cnt = m_cnt + 1;
            end else if (m_cnt == '0) begin
                n_down = 0; n_cnt = 1;
            end else n_cnt = m_cnt - 1;
        end
        if (m_evt && tog_en) m_ref = ~m_ref;
        if (m_evt) m_flag = 1; else if (flag_clr) m_flag = 0;
        if (m_upd && preload) begin m_cmp = m_csh; m_arr = m_ash; end
        if (wr_en) begin
            if (!wr_sel) begin m_csh = wr_data; if (!preload) m_cmp = wr_data; end
            else begin m_ash = wr_data; if (!preload) m_arr = wr_data; end
        end
        if (opp) m_rep = (m_rep == '0) ? rep_val : m_rep - 1;
        m_cnt = n_cnt; m_down = n_down;
    endtask

    // one clock: inputs already set at the falling edge
    task automatic tick(input string tg);
        string t_evt, t_upd, t_cnt, t_ref, t_flg;
        t_evt = (tg == "") ? "R4" : tg;
        t_upd = (tg == "") ? "R12" : tg;
        t_cnt = (tg == "") ? (center ? "R3" : "R2") : tg;
        t_ref = (tg == "") ? "R8" : tg;
        t_flg = (tg == "") ? "R9" : tg;
        #1;
        m_evt = en && (m_cnt == m_cmp);
        m_upd = en && f_opp(m_cnt, m_down, center, m_arr) && (m_rep == '0);
        chk(cmp_evt === m_evt, t_evt, "cmp_evt", 32'(cmp_evt), 32'(m_evt));
        chk(upd_evt === m_upd, t_upd, "upd_evt", 32'(upd_evt), 32'(m_upd));
        seen_evt = cmp_evt;
        model_step();
        @(negedge clk);
        chk(cnt === m_cnt, t_cnt, "cnt", 32'(cnt), 32'(m_cnt));
        chk(count_down === m_down, t_cnt, "count_down", 32'(count_down), 32'(m_down));
        chk(oc_ref === m_ref, t_ref, "oc_ref", 32'(oc_ref), 32'(m_ref));
        chk(cmp_flag === m_flag, t_flg, "cmp_flag", 32'(cmp_flag), 32'(m_flag));
    endtask

    task automatic write(input logic sel, input logic [CW-1:0] d, input string tg);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick(tg);
        wr_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic r0, r1, r2;
        int guard, n_upd, n_opp;
        logic [CW-1:0] c_hold;
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(cnt === '0, "R1", "cnt", 32'(cnt), 0);
        chk(count_down === 1'b0, "R1", "count_down", 32'(count_down), 0);
        chk(oc_ref === 1'b0, "R1", "oc_ref", 32'(oc_ref), 0);
        chk(cmp_flag === 1'b0, "R1", "cmp_flag", 32'(cmp_flag), 0);
        @(negedge clk);

        // R1: default reload/compare seen while running edge-aligned
        en = 1; preload = 1; tog_en = 1;
        for (int i = 0; i < 12; i++) tick("R1");

        // R5: edge wrap, compare ARR -> 0 via preload
        en = 0; preload = 0;
        write(1'b1, 16'd5, "R10");
        write(1'b0, 16'd5, "R10");
        preload = 1;
        write(1'b0, 16'd0, "R11");
        en = 1;
        guard = 0;
        while (m_cnt != 5 && guard < 40) begin tick("R5"); guard++; end
        r0 = oc_ref;
        tick("R5"); r1 = oc_ref;
        chk(seen_evt === 1'b1, "R5", "event at ARR", 32'(seen_evt), 1);
        tick("R5"); r2 = oc_ref;
        chk(seen_evt === 1'b1, "R5", "event at 0", 32'(seen_evt), 1);
        chk(r1 === ~r0 && r2 === r0, "R8", "pulse shape", {29'd0, r0, r1, r2},
            {29'd0, r0, ~r0, r0});

        // R6: crest, compare ARR-1 -> ARR
        en = 0; preload = 0; center = 1;
        write(1'b1, 16'd6, "R10");
        write(1'b0, 16'd5, "R10");
        en = 1;
        guard = 0;
        while (!(m_cnt == 5 && !m_down) && guard < 40) begin tick("R6"); guard++; end
        write(1'b0, 16'd6, "R6");
        chk(seen_evt === 1'b1, "R6", "event at ARR-1", 32'(seen_evt), 1);
        tick("R6");
        chk(seen_evt === 1'b1, "R6", "event at ARR", 32'(seen_evt), 1);

        // R7: valley, compare 1 -> 0
        write(1'b0, 16'd1, "R7");
        guard = 0;
        while (!(m_cnt == 1 && m_down) && guard < 40) begin tick("R7"); guard++; end
        r0 = oc_ref;
        write(1'b0, 16'd0, "R7");
        chk(seen_evt === 1'b1, "R7", "event at 1", 32'(seen_evt), 1);
        r1 = oc_ref;
        tick("R7");
        chk(seen_evt === 1'b1, "R7", "event at 0", 32'(seen_evt), 1);
        r2 = oc_ref;
        chk(r1 === ~r0 && r2 === r0, "R8", "valley pulse", {29'd0, r0, r1, r2},
            {29'd0, r0, ~r0, r0});

        // R9 / R4: clear while stopped, counter frozen
        en = 0; flag_clr = 1; c_hold = cnt;
        tick("R9");
        flag_clr = 0;
        chk(cmp_flag === 1'b0, "R9", "flag cleared", 32'(cmp_flag), 0);
        tick("R4");
        chk(cnt === c_hold, "R4", "frozen cnt", 32'(cnt), 32'(c_hold));

        // R11: preload holds new values until update
        center = 0; preload = 0;
        write(1'b1, 16'd4, "R10");
        write(1'b0, 16'd2, "R10");
        preload = 1;
        write(1'b0, 16'd3, "R11");
        write(1'b1, 16'd7, "R11");
        en = 1;
        for (int i = 0; i < 20; i++) tick("R11");

        // R12: repetition count gates update events
        rep_val = 4'd2; n_upd = 0; n_opp = 0;
        write(1'b1, 16'd2, "R12");
        for (int i = 0; i < 45; i++) begin
            if (f_opp(m_cnt, m_down, center, m_arr)) n_opp++;
            tick("R12");
            if (upd_evt === 1'b1) n_upd++;
        end
        #1;
        chk(n_upd > 0 && n_upd < n_opp, "R12", "updates vs points", n_upd, n_opp);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            en       = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 39) == 0) center = ~center;
            preload  = $urandom_range(0, 1);
            tog_en   = ($urandom_range(0, 4) != 0);
            flag_clr = ($urandom_range(0, 9) == 0);
            wr_en    = ($urandom_range(0, 4) == 0);
            wr_sel   = $urandom_range(0, 1);
            wr_data  = wr_sel ? CW'($urandom_range(1, 10)) : CW'($urandom_range(0, 11));
            if ($urandom_range(0, 99) == 0) rep_val = RW'($urandom_range(0, 3));
            tick("");
        end
        wr_en = 0;

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule